// File: doc/BRIEF.md
# Configurable UART frame engine

This block holds the serial transmit and receive engines of an asynchronous serial port. The transmitter takes bytes from a valid/ready stream that a transmit FIFO feeds. It sends each byte as a start bit, the data bits, an optional parity bit and one or two stop bits. The receiver watches the line and checks the parity bit and the stop bits. It then presents each character on a valid/ready output stream, together with per-character error flags and a line-break indication. Framing and parity errors are also collected in sticky status outputs, which stay set until software clears them.

The frame format comes from plain configuration inputs that the port's control word drives: a 2-bit data-length code, a 2-bit stop-length code, a parity enable and a parity-type select. A two-wire mode turns the CTS/RTS handshake off. When the handshake is on, the transmitter starts a frame only while CTS is asserted (active low). The receiver asserts RTS (active low) while it can accept a character. Two ticks from an external baud generator set the timing: a one-per-bit tick for the transmitter and a 16x oversample tick for the receiver.

Back-pressure rules: `tx_ready` is high only in a cycle where a frame may start. That cycle carries a bit tick, has the transmitter enabled and CTS satisfied, and finds the engine idle or in the final tick of the last stop bit. A byte is taken when `tx_valid && tx_ready`. On the receive side, `rx_valid` and its data and flags hold steady until `rx_ready` is seen. A character that completes while the output slot is still full is discarded.

Top module: `uart_frame_engine`

## Requirements
- R1: The data-length code `cfg_data_len` (control word bits [21:20]) selects the number of data bits: 0 gives 8, 1 gives 7, 2 gives 6 and 3 gives 5. Received data is right-aligned, and the unused upper bits read 0.
- R2: The line idles high. A frame begins on a bit tick with a low start bit, followed by the data bits least significant bit first. Every bit lasts exactly one bit-tick period, and `txd` changes only in cycles carrying a bit tick.
- R3: With `cfg_par_en`=1, a parity bit follows the data. It is even parity when `cfg_par_odd`=0 and odd parity when it is 1. The receiver flags `rx_par_err` on a mismatch. With `cfg_par_en`=0, no parity bit is sent or expected.
- R4: The stop-length code `cfg_stop_len` (control word bits [17:16]) gives one stop bit for 0 and two stop bits for 1. Codes 2 and 3 act as one stop bit.
- R5: With `cfg_two_wire`=0, no frame starts while `cts_n` is high. With `cfg_two_wire`=1, `cts_n` is ignored.
- R6: With `cfg_two_wire`=0, `rts_n` is low exactly while the receiver is enabled and its output slot is empty. With `cfg_two_wire`=1, `rts_n` stays high.
- R7: The receiver confirms a start bit at its middle, eight oversample ticks after the falling edge. A low pulse that has ended by then starts no frame. Later bits are sampled at their centres.
- R8: `rx_frame_err` is set when any expected stop bit is sampled low. `rx_break` is set when a framing error comes with an all-zero data value.
- R9: `stat_frame_err` and `stat_par_err` go high when a character completes with that error. They stay high until `err_clear` is asserted.
- R10: `tx_busy` is high from the start bit to the end of the last stop bit. `tx_idle` is high only when `tx_busy` is low and `tx_valid` is low.
- R11: `rx_valid` and its data and flags hold steady until `rx_ready`. A character that completes while the slot is full is dropped.
- R12: Dropping `tx_en` or `rx_en` stops new frames from starting, but a frame already in progress runs to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per bit period |
| os_tick | input | 1 | Oversample pulse, 16 per bit period |
| cfg_data_len | input | 2 | Data-length code |
| cfg_stop_len | input | 2 | Stop-length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_wire | input | 1 | 1 turns the CTS/RTS handshake off |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| err_clear | input | 1 | Clears the sticky error flags |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| tx_data | input | 8 | Transmit byte |
| txd | output | 1 | Serial output |
| tx_busy | output | 1 | A frame is being shifted out |
| tx_idle | output | 1 | Nothing queued and nothing shifting |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | Received character available |
| rx_ready | input | 1 | Consumer takes the character |
| rx_data | output | 8 | Received data, right-aligned |
| rx_frame_err | output | 1 | Character had a stop-bit error |
| rx_par_err | output | 1 | Character had a parity error |
| rx_break | output | 1 | Character is a line break |
| stat_frame_err | output | 1 | Sticky framing error |
| stat_par_err | output | 1 | Sticky parity error |

## Verification
The bench decodes `txd` on its own for each length, parity and stop combination. This catches a reversed length code, a wrong parity sense, or a second stop bit that is dropped or added. It drives hand-built frames with bad parity, a low stop bit and an all-zero break, which expose a break flag raised on non-zero data and sticky flags that clear themselves. It also injects a short start glitch, which a receiver without the mid-bit check would accept as a character. Further cases cover CTS blocking and two-wire bypass, RTS tracking the output slot, a second character arriving into a full slot (it must not overwrite), and enables dropped mid-frame (the frame must not be cut short).

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int MAX_BITS = 8;
  localparam int CNT_W    = $clog2(MAX_BITS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } fe_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fe_cfg_t;

  // Index of the last data bit for a length code (code 0 -> 7 ... code 3 -> 4)
  function automatic logic [CNT_W-1:0] last_bit(input logic [1:0] code);
    return CNT_W'(MAX_BITS - 1) - CNT_W'(code);
  endfunction

  function automatic logic [MAX_BITS-1:0] keep_bits(input logic [MAX_BITS-1:0] d,
                                                    input logic [1:0] code);
    return d & ({MAX_BITS{1'b1}} >> code);
  endfunction
endpackage

// File: rtl/uart_fe_sync.sv
module uart_fe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r[i] <= RST_VAL;
        else        r[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r[i] <= RST_VAL;
        else        r[i] <= r[i-1];
    end
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/uart_fe_tx.sv
module uart_fe_tx
  import uart_fe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                tx_en,
  input  logic                cts_ok,
  input  fe_cfg_t             cfg,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_BITS-1:0] tx_data,
  output logic                txd,
  output logic                tx_busy
);
  fe_state_e           st;
  fe_cfg_t             lcfg;
  logic [MAX_BITS-1:0] sh;
  logic [CNT_W-1:0]    left;
  logic                parb;
  logic                stop_more;
  logic                frame_end;
  logic                take;
  logic [MAX_BITS-1:0] masked;

  assign frame_end = (st == ST_STOP) && !stop_more;
  assign tx_ready  = bit_tick && tx_en && cts_ok && ((st == ST_IDLE) || frame_end);
  assign take      = tx_ready && tx_valid;
  assign masked    = keep_bits(tx_data, cfg.len_code);
  assign tx_busy   = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lcfg      <= '0;
      sh        <= '0;
      left      <= '0;
      parb      <= 1'b0;
      stop_more <= 1'b0;
      txd       <= 1'b1;
    end else if (take) begin
      st   <= ST_START;
      txd  <= 1'b0;
      sh   <= masked;
      parb <= (^masked) ^ cfg.par_odd;
      lcfg <= cfg;
    end else if (bit_tick) begin
      unique case (st)
        ST_START: begin
          txd  <= sh[0];
          sh   <= sh >> 1;
          left <= last_bit(lcfg.len_code);
          st   <= ST_DATA;
        end
        ST_DATA: begin
          if (left != '0) begin
            txd  <= sh[0];
            sh   <= sh >> 1;
            left <= left - 1'b1;
          end else if (lcfg.par_en) begin
            txd <= parb;
            st  <= ST_PAR;
          end else begin
            txd       <= 1'b1;
            stop_more <= lcfg.two_stop;
            st        <= ST_STOP;
          end
        end
        ST_PAR: begin
          txd       <= 1'b1;
          stop_more <= lcfg.two_stop;
          st        <= ST_STOP;
        end
        ST_STOP: begin
          if (stop_more) stop_more <= 1'b0;
          else           st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_rx.sv
module uart_fe_rx
  import uart_fe_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                os_tick,
  input  logic                rx_en,
  input  logic                rxs,
  input  fe_cfg_t             cfg,
  input  logic                err_clear,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [MAX_BITS-1:0] out_data,
  output logic                out_ferr,
  output logic                out_perr,
  output logic                out_brk,
  output logic                stat_ferr,
  output logic                stat_perr
);
  localparam int OC_W = $clog2(OS_RATE);
  localparam logic [OC_W-1:0] OC_HALF = OC_W'(OS_RATE / 2 - 1);
  localparam logic [OC_W-1:0] OC_LAST = OC_W'(OS_RATE - 1);

  fe_state_e           st;
  fe_cfg_t             lcfg;
  logic [OC_W-1:0]     oc;
  logic [CNT_W-1:0]    idx;
  logic [MAX_BITS-1:0] sh;
  logic                parb, ferr, stop_more, armed;
  logic                sample, fin, fin_ferr, fin_perr, slot_free;

  assign sample    = os_tick && (oc == OC_LAST);
  assign fin       = (st == ST_STOP) && sample && !stop_more;
  assign fin_ferr  = ferr | ~rxs;
  assign fin_perr  = lcfg.par_en & (parb != ((^sh) ^ lcfg.par_odd));
  assign slot_free = !out_valid || out_ready;

  // Bit-level state machine
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; lcfg <= '0; oc <= '0; idx <= '0; sh <= '0;
      parb <= 1'b0; ferr <= 1'b0; stop_more <= 1'b0; armed <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (rxs) armed <= 1'b1;
          if (rx_en && armed && !rxs) begin
            st   <= ST_START;
            oc   <= '0;
            lcfg <= cfg;
          end
        end
        ST_START: if (os_tick) begin
          if (oc == OC_HALF) begin
            oc <= '0;
            if (!rxs) begin
              st <= ST_DATA; idx <= '0; sh <= '0; ferr <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            oc <= oc + 1'b1;
          end
        end
        default: if (os_tick) begin
          oc <= sample ? '0 : oc + 1'b1;
          if (sample) begin
            unique case (st)
              ST_DATA: begin
                sh[idx] <= rxs;
                if (idx == last_bit(lcfg.len_code)) begin
                  if (lcfg.par_en) st <= ST_PAR;
                  else begin
                    st        <= ST_STOP;
                    stop_more <= lcfg.two_stop;
                  end
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              ST_PAR: begin
                parb      <= rxs;
                st        <= ST_STOP;
                stop_more <= lcfg.two_stop;
              end
              default: begin
                if (!rxs) ferr <= 1'b1;
                if (stop_more) stop_more <= 1'b0;
                else begin
                  st    <= ST_IDLE;
                  armed <= 1'b0;
                end
              end
            endcase
          end
        end
      endcase
    end
  end

  // Output slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0;
      out_ferr  <= 1'b0; out_perr <= 1'b0; out_brk <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fin && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= sh;
        out_ferr  <= fin_ferr;
        out_perr  <= fin_perr;
        out_brk   <= fin_ferr && (sh == '0);
      end
    end
  end

  // Sticky status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_ferr <= 1'b0;
      stat_perr <= 1'b0;
    end else begin
      if (err_clear) begin
        stat_ferr <= 1'b0;
        stat_perr <= 1'b0;
      end
      if (fin && fin_ferr) stat_ferr <= 1'b1;
      if (fin && fin_perr) stat_perr <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
  import uart_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OS_RATE     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       os_tick,
  input  logic [1:0] cfg_data_len,
  input  logic [1:0] cfg_stop_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_wire,
  input  logic       tx_en,
  input  logic       rx_en,
  input  logic       err_clear,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  output logic       txd,
  output logic       tx_busy,
  output logic       tx_idle,
  input  logic       cts_n,
  output logic       rts_n,
  input  logic       rxd,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_frame_err,
  output logic       rx_par_err,
  output logic       rx_break,
  output logic       stat_frame_err,
  output logic       stat_par_err
);
  fe_cfg_t cfg;
  logic    rxs, cts_s, cts_ok;

  assign cfg.len_code = cfg_data_len;
  assign cfg.par_en   = cfg_par_en;
  assign cfg.par_odd  = cfg_par_odd;
  assign cfg.two_stop = (cfg_stop_len == 2'd1);

  uart_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs));

  uart_fe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s));

  assign cts_ok = cfg_two_wire || !cts_s;

  uart_fe_tx u_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .cts_ok(cts_ok), .cfg(cfg), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .txd(txd), .tx_busy(tx_busy));

  uart_fe_rx #(.OS_RATE(OS_RATE)) u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_en(rx_en), .rxs(rxs),
    .cfg(cfg), .err_clear(err_clear), .out_ready(rx_ready),
    .out_valid(rx_valid), .out_data(rx_data), .out_ferr(rx_frame_err),
    .out_perr(rx_par_err), .out_brk(rx_break),
    .stat_ferr(stat_frame_err), .stat_perr(stat_par_err));

  assign tx_idle = !tx_busy && !tx_valid;
  assign rts_n   = cfg_two_wire || !rx_en || rx_valid;
endmodule

// File: rtl/uart_frame_engine_chk.sv
module uart_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       tx_en,
  input logic       err_clear,
  input logic       tx_ready,
  input logic       txd,
  input logic       tx_busy,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_frame_err,
  input logic       rx_par_err,
  input logic       rx_break,
  input logic       stat_frame_err,
  input logic       stat_par_err
);
  // R11: held output until taken
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) &&
      $stable(rx_frame_err) && $stable(rx_par_err) && $stable(rx_break));

  // R8: break only with framing error on zero data
  p_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_break |-> rx_frame_err && (rx_data == 8'h00));

  // R9: sticky flags persist without clear
  p_sticky_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_frame_err && !err_clear |=> stat_frame_err);

  p_sticky_par_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_par_err && !err_clear |=> stat_par_err);

  // R9: a freshly delivered error is reflected in status
  p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && rx_frame_err |-> stat_frame_err);

  // R10: idle transmitter holds the line high
  p_idle_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R2: line changes only on a bit tick
  p_tick_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick));

  // R12: no start while disabled
  p_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bit_tick && tx_en);
endmodule

bind uart_frame_engine uart_frame_engine_chk u_chk (.*);

// File: tb/uart_frame_engine_test.sv
module uart_frame_engine_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       os_tick = 1'b1;
  logic [1:0] cfg_data_len = 2'd0, cfg_stop_len = 2'd0;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_wire = 1'b1;
  logic       tx_en = 1'b1, rx_en = 1'b1, err_clear = 1'b0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0, cts_n = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       loop_sel = 1'b1, drv_rxd = 1'b1;
  logic       tx_ready, txd, tx_busy, tx_idle, rts_n, rxd, rx_valid;
  logic [7:0] rx_data;
  logic       rx_frame_err, rx_par_err, rx_break, stat_frame_err, stat_par_err;
  logic [3:0] tcnt = 4'd0;

  assign rxd = loop_sel ? txd : drv_rxd;

  always @(posedge clk) begin
    tcnt     <= tcnt + 4'd1;
    bit_tick <= (tcnt == 4'd14);
  end

  uart_frame_engine uut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL all watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d);
    int k = 0;
    tx_data = d; tx_valid = 1'b1;
    while (!tx_ready && k < 3000) begin @(negedge clk); k++; end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // Independent decoder of txd; code 0 = good frame
  task automatic decode_tx(input int n, input bit pe, input bit po, input bit two,
                           output logic [7:0] got, output int code);
    int k = 0;
    got = 8'h00; code = 0;
    while (txd && k < 3000) begin @(negedge clk); k++; end
    if (txd) begin code = 5; return; end
    waitn(7);
    if (txd) code = 1;
    for (int i = 0; i < n; i++) begin waitn(16); got[i] = txd; end
    if (pe) begin
      waitn(16);
      if (txd != ((^got) ^ po)) code = 2;
    end
    waitn(16);
    if (!txd || !tx_busy) code = 3;
    if (two) begin waitn(16); if (!txd || !tx_busy) code = 3; end
    waitn(16);
    if (tx_busy) code = 4;
  endtask

  task automatic get_rx(output logic [7:0] d, output logic fe, output logic pe,
                        output logic brk, output bit seen);
    int k = 0;
    while (!rx_valid && k < 600) begin @(negedge clk); k++; end
    seen = rx_valid; d = rx_data; fe = rx_frame_err; pe = rx_par_err; brk = rx_break;
    if (seen) begin rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; end
  endtask

  task automatic drive_frame(input logic [7:0] d, input int n, input bit pe,
                             input bit po, input int nstop, input bit badpar,
                             input bit badstop);
    loop_sel = 1'b0;
    drv_rxd = 1'b0; waitn(16);
    for (int i = 0; i < n; i++) begin drv_rxd = d[i]; waitn(16); end
    if (pe) begin
      drv_rxd = (^(d & (8'hFF >> (8 - n)))) ^ po ^ badpar; waitn(16);
    end
    for (int i = 0; i < nstop; i++) begin
      drv_rxd = (i == 0) ? !badstop : 1'b1; waitn(16);
    end
    drv_rxd = 1'b1; waitn(16);
  endtask

  typedef struct packed {
    logic [7:0] d; logic [1:0] len; logic pe; logic po; logic [1:0] stp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'hA5, 2'd0, 1'b0, 1'b0, 2'd0},
    '{8'h3C, 2'd0, 1'b1, 1'b0, 2'd0},
    '{8'h81, 2'd0, 1'b1, 1'b1, 2'd1},
    '{8'hFF, 2'd1, 1'b1, 1'b0, 2'd0},
    '{8'h6B, 2'd2, 1'b0, 1'b0, 2'd1},
    '{8'hF3, 2'd3, 1'b1, 1'b1, 2'd0},
    '{8'h2E, 2'd3, 1'b0, 1'b0, 2'd2},
    '{8'h00, 2'd1, 1'b1, 1'b1, 2'd1}
  };

  initial begin
    logic [7:0] got, rd, exp;
    logic fe, pe, brk;
    bit seen, any_busy, any_ready;
    int code;

    waitn(5);
    rst_n = 1'b1;
    waitn(3);
    // Reset state (R10, R6)
    chk(txd == 1'b1 && tx_busy == 1'b0 && tx_idle == 1'b1, "R10", "reset tx", {txd, tx_busy, tx_idle}, 3'b101);
    chk(rx_valid == 1'b0 && stat_frame_err == 1'b0 && stat_par_err == 1'b0 && rts_n == 1'b1,
        "R6", "reset rx", {rx_valid, stat_frame_err, stat_par_err, rts_n}, 4'b0001);

    // Vector table: loopback frames (R1 R2 R3 R4)
    foreach (VECS[v]) begin
      cfg_data_len = VECS[v].len; cfg_par_en = VECS[v].pe;
      cfg_par_odd = VECS[v].po; cfg_stop_len = VECS[v].stp;
      exp = VECS[v].d & (8'hFF >> VECS[v].len);
      fork
        send_byte(VECS[v].d);
        decode_tx(8 - int'(VECS[v].len), VECS[v].pe, VECS[v].po, VECS[v].stp == 2'd1, got, code);
      join
      chk(code == 0, "R4", "tx frame shape", code, 0);
      chk(got == exp, "R2", "tx data bits", got, exp);
      chk(tx_idle == 1'b1, "R10", "idle after frame", tx_idle, 1);
      get_rx(rd, fe, pe, brk, seen);
      chk(seen && rd == exp, "R1", "rx data", rd, exp);
      chk(!fe && !pe && !brk, "R3", "rx flags clean", {fe, pe, brk}, 0);
    end
    cfg_data_len = 2'd0; cfg_par_en = 1'b0; cfg_par_odd = 1'b0; cfg_stop_len = 2'd0;

    // CTS blocks start (R5), queued byte keeps tx_idle low (R10)
    cfg_two_wire = 1'b0; cts_n = 1'b1;
    tx_data = 8'h33; tx_valid = 1'b1;
    any_busy = 0; any_ready = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk); any_busy |= tx_busy; any_ready |= tx_ready;
    end
    chk(!any_busy && !any_ready && txd, "R5", "cts high blocks", {any_busy, any_ready}, 0);
    chk(tx_idle == 1'b0, "R10", "queued not idle", tx_idle, 0);
    cts_n = 1'b0;
    fork
      send_byte(8'h33);
      decode_tx(8, 0, 0, 0, got, code);
    join
    chk(code == 0 && got == 8'h33, "R5", "cts low sends", got, 8'h33);
    get_rx(rd, fe, pe, brk, seen);
    chk(seen && rd == 8'h33, "R5", "cts frame received", rd, 8'h33);

    // RTS and output slot (R6 R11)
    chk(rts_n == 1'b0, "R6", "rts asserted when empty", rts_n, 0);
    fork
      send_byte(8'h5C);
      decode_tx(8, 0, 0, 0, got, code);
    join
    waitn(2);
    chk(rx_valid && rts_n == 1'b1, "R6", "rts released when full", {rx_valid, rts_n}, 2'b11);
    drive_frame(8'h0F, 8, 0, 0, 1, 0, 0);
    chk(rx_valid && rx_data == 8'h5C, "R11", "full slot kept", rx_data, 8'h5C);
    get_rx(rd, fe, pe, brk, seen);
    waitn(4);
    chk(rd == 8'h5C && !rx_valid, "R11", "second char dropped", rx_valid, 0);
    chk(rts_n == 1'b0, "R6", "rts back", rts_n, 0);
    cfg_two_wire = 1'b1; cts_n = 1'b1;
    waitn(2);
    chk(rts_n == 1'b1, "R6", "two-wire rts high", rts_n, 1);

    // Two-wire ignores cts (R5)
    fork
      send_byte(8'hC3);
      decode_tx(8, 0, 0, 0, got, code);
    join
    chk(code == 0 && got == 8'hC3, "R5", "two-wire ignores cts", got, 8'hC3);
    get_rx(rd, fe, pe, brk, seen);

    // Break and framing (R8 R9)
    drive_frame(8'h00, 8, 0, 0, 1, 0, 1);
    get_rx(rd, fe, pe, brk, seen);
    chk(seen && fe && brk && rd == 8'h00, "R8", "break", {fe, brk}, 2'b11);
    drive_frame(8'h41, 8, 0, 0, 1, 0, 1);
    get_rx(rd, fe, pe, brk, seen);
    chk(seen && fe && !brk && rd == 8'h41, "R8", "frame err not break", {fe, brk}, 2'b10);
    waitn(20);
    chk(stat_frame_err == 1'b1, "R9", "sticky frame held", stat_frame_err, 1);
    err_clear = 1'b1; waitn(1); err_clear = 1'b0; waitn(1);
    chk(stat_frame_err == 1'b0, "R9", "frame cleared", stat_frame_err, 0);

    // Parity error (R3 R9)
    cfg_par_en = 1'b1; cfg_par_odd = 1'b1;
    drive_frame(8'h3C, 8, 1, 1, 1, 1, 0);
    get_rx(rd, fe, pe, brk, seen);
    chk(seen && pe && !fe, "R3", "parity error", {pe, fe}, 2'b10);
    chk(stat_par_err == 1'b1, "R9", "sticky parity", stat_par_err, 1);
    err_clear = 1'b1; waitn(1); err_clear = 1'b0; waitn(1);
    chk(stat_par_err == 1'b0, "R9", "parity cleared", stat_par_err, 0);
    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // Start glitch (R7)
    loop_sel = 1'b0; drv_rxd = 1'b0; waitn(4); drv_rxd = 1'b1;
    waitn(300);
    chk(!rx_valid, "R7", "glitch rejected", rx_valid, 0);

    // Receiver disable (R12)
    rx_en = 1'b0;
    drive_frame(8'h77, 8, 0, 0, 1, 0, 0);
    waitn(40);
    chk(!rx_valid, "R12", "rx disabled ignores frame", rx_valid, 0);
    rx_en = 1'b1; waitn(4);
    fork
      drive_frame(8'h96, 8, 0, 0, 1, 0, 0);
      begin waitn(40); rx_en = 1'b0; end
    join
    get_rx(rd, fe, pe, brk, seen);
    chk(seen && rd == 8'h96, "R12", "rx frame in flight completes", rd, 8'h96);
    rx_en = 1'b1;
    loop_sel = 1'b1;

    // Transmitter disable (R12)
    fork
      send_byte(8'hA5);
      begin
        while (txd) @(negedge clk);
        waitn(30); tx_en = 1'b0;
      end
      decode_tx(8, 0, 0, 0, got, code);
    join
    chk(code == 0 && got == 8'hA5, "R12", "tx frame in flight completes", got, 8'hA5);
    get_rx(rd, fe, pe, brk, seen);
    tx_data = 8'h11; tx_valid = 1'b1; any_busy = 0;
    for (int i = 0; i < 80; i++) begin @(negedge clk); any_busy |= tx_busy; end
    chk(!any_busy, "R12", "tx disabled no start", any_busy, 0);
    tx_valid = 1'b0; tx_en = 1'b1;

    waitn(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule